// File: doc/BRIEF.md
# Monochrome Passive Panel Line and Frame Timer

This block drives a single-scan monochrome passive LCD panel that takes eight pixels per shift clock over an 8-bit data bus. Running from the pixel clock, it produces the panel's frame pulse, line pulse, shift clock, AC-drive toggle and data byte. Each line has two parts. The active part carries W+1 groups of eight pixel clocks, and each group transfers one byte. The blank part is N+4 groups long, and the line pulse is placed inside it.

Pixel bytes arrive on a ready/valid stream. The block requests one byte per active group. If no byte is offered when one is requested, it sends zero to the panel and sets a sticky underflow flag. The width and blank fields are captured at the start of every line, so software may rewrite them at any time without producing a torn line. A programmable line count sets the frame length. The frame pulse brackets the line pulse that closes the last line of a frame, and the AC-drive toggle flips once per frame.

Top module: `lcd_panel_timer`

## Requirements
- R1: While `rst` is high, `lcd_frame`, `lcd_line`, `lcd_shift`, `lcd_mod`, `lcd_data`, `underflow` and `pix_ready` are all 0.
- R2: The line pulse repeats every (W+1)*8 + (N+4)*8 pixel clocks, where W = `cfg_width` and N = `cfg_blank`.
- R3: The line pulse is high for exactly 9 clocks. With the mask on, it rises 8*N+4 clocks after the last shift falling edge of the active part, so it falls 8*N+13 clocks after that edge.
- R4: With `cfg_mask_shift` = 1, each line has exactly W+1 shift falling edges, and `lcd_shift` stays low while `lcd_line` is high.
- R5: With `cfg_mask_shift` = 0, the shift clock keeps its 8-clock period through the blank part, giving one falling edge per group: line period / 8 edges per line.
- R6: `lcd_frame` rises 13 clocks before the falling edge of the line pulse of line `cfg_lines`, and falls 4 clocks after that edge. It therefore repeats every (`cfg_lines`+1) line periods.
- R7: `lcd_mod` changes exactly once per frame, MOD_DLY clocks (default 3) after the rising edge of that frame's last line pulse.
- R8: One byte is accepted in each active group, in a cycle where `pix_ready` and `pix_valid` are both high. The k-th accepted byte of a line is on `lcd_data` at the k-th shift falling edge, and `lcd_data` is 0 while `lcd_line` is high.
- R9: A group whose request meets `pix_valid` = 0 puts 0 on `lcd_data` at its shift falling edge and sets `underflow`. `underflow` stays 1 until reset and never rises while data is always valid.
- R10: A change to `cfg_width` in the middle of a line takes effect from the next line. The current line keeps its shift-edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| cfg_width | input | WW | display width W, in 8-pixel groups minus one |
| cfg_blank | input | NW | blank field N; blank part lasts N+4 groups |
| cfg_lines | input | LW | lines per frame minus one |
| cfg_mask_shift | input | 1 | 1 holds the shift clock low outside the active part |
| pix_data | input | DW | pixel byte stream data |
| pix_valid | input | 1 | stream byte present |
| pix_ready | output | 1 | block takes a byte this cycle |
| lcd_frame | output | 1 | frame pulse |
| lcd_line | output | 1 | line pulse |
| lcd_shift | output | 1 | shift clock, panel samples on falling edge |
| lcd_mod | output | 1 | AC drive toggle |
| lcd_data | output | DW | panel data byte |
| underflow | output | 1 | sticky flag for a missed byte |

## Verification
The bench measures every interval between panel edges rather than absolute cycle numbers. A design that counted the blank part as N groups instead of N+4, or that placed the line pulse from the start of the blank part instead of from the last shift edge, shows up as a wrong period or a wrong gap. Both shift-mask settings are run. A mask that leaks shift edges into the blank part gives too many edges per line, and a mask wired backwards gives too few. The frame pulse is timed against the line falling edge on both sides, which catches a pulse on the wrong line or a missing hold. A mid-line width change catches a design that reads the width live instead of once per line. A starved stream checks both the zero data and the flag that must not clear itself.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
   // pixel clocks per shift group, as a power of two
   localparam int GROUP_SH = 3;
   // offsets of the line pulse edges past the end of the blank field
   localparam int LP_RISE_OFS = 4;
   localparam int LP_FALL_OFS = 13;
   // frame pulse window around the line pulse falling edge
   localparam int FR_SETUP = 13;
   localparam int FR_HOLD  = 4;
   // phase inside a group at which a byte is requested
   localparam logic [GROUP_SH-1:0] FETCH_PH = 3'd2;
   // groups added to the blank field
   localparam int BLANK_EXTRA = 4;

   function automatic int max_line_len(input int ww, input int nw);
      return ((1 << ww) << GROUP_SH) + (((1 << nw) + BLANK_EXTRA - 1) << GROUP_SH);
   endfunction
endpackage

// File: rtl/lcdt_hcount.sv
`timescale 1ns/1ps
module lcdt_hcount
   import lcdt_pkg::*;
#(
   parameter int WW = 7,
   parameter int NW = 5,
   parameter int HW = 11,
   parameter int MOD_DLY = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [WW-1:0] cfg_width,
   input  logic [NW-1:0] cfg_blank,
   input  logic          mask,
   output logic          line_end,
   output logic          fetch,
   output logic          blank_tick,
   output logic          shift_c,
   output logic          line_c,
   output logic          frame_win,
   output logic          mod_hit
);
   logic [HW-1:0]       hcnt;
   logic [WW-1:0]       w_q;
   logic [NW-1:0]       n_q;
   logic [HW-1:0]       act_end, blank_len, nd, line_last;
   logic [HW-1:0]       lp_rise, lp_fall, fr_on, fr_off, mod_at;
   logic [GROUP_SH-1:0] phase;
   logic                act;

   always_comb begin
      act_end   = (HW'(w_q) + HW'(1)) << GROUP_SH;
      blank_len = (HW'(n_q) + HW'(BLANK_EXTRA)) << GROUP_SH;
      nd        = HW'(n_q) << GROUP_SH;
      line_last = act_end + blank_len - HW'(1);
      lp_rise   = act_end + nd + HW'(LP_RISE_OFS);
      lp_fall   = act_end + nd + HW'(LP_FALL_OFS);
      fr_on     = lp_fall - HW'(FR_SETUP);
      fr_off    = lp_fall + HW'(FR_HOLD);
      mod_at    = lp_rise + HW'(MOD_DLY - 1);
   end

   assign phase      = hcnt[GROUP_SH-1:0];
   assign act        = hcnt < act_end;
   assign line_end   = hcnt == line_last;
   assign fetch      = act && (phase == FETCH_PH);
   assign blank_tick = !act && (phase == FETCH_PH);
   assign shift_c    = (act || !mask) && hcnt[GROUP_SH-1];
   assign line_c     = (hcnt >= lp_rise) && (hcnt < lp_fall);
   assign frame_win  = (hcnt >= fr_on) && (hcnt < fr_off);
   assign mod_hit    = hcnt == mod_at;

   // geometry fields are captured only at a line boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt <= '0;
         w_q  <= cfg_width;
         n_q  <= cfg_blank;
      end else if (line_end) begin
         hcnt <= '0;
         w_q  <= cfg_width;
         n_q  <= cfg_blank;
      end else begin
         hcnt <= hcnt + HW'(1);
      end
   end
endmodule

// File: rtl/lcdt_vcount.sv
`timescale 1ns/1ps
module lcdt_vcount #(
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_end,
   input  logic [LW-1:0] cfg_lines,
   input  logic          frame_win,
   input  logic          mod_hit,
   output logic          frame_c,
   output logic          mod_i
);
   logic [LW-1:0] vcnt;
   logic          last_line;

   assign last_line = vcnt >= cfg_lines;
   assign frame_c   = last_line && frame_win;

   always_ff @(posedge clk) begin
      if (rst) begin
         vcnt  <= '0;
         mod_i <= 1'b0;
      end else begin
         if (line_end) vcnt <= last_line ? '0 : vcnt + LW'(1);
         if (last_line && mod_hit) mod_i <= ~mod_i;
      end
   end
endmodule

// File: rtl/lcdt_fetch.sv
`timescale 1ns/1ps
module lcdt_fetch #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fetch,
   input  logic          blank_tick,
   input  logic [DW-1:0] pix_data,
   input  logic          pix_valid,
   output logic          pix_ready,
   output logic [DW-1:0] data_q,
   output logic          underflow
);
   assign pix_ready = fetch;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q    <= '0;
         underflow <= 1'b0;
      end else if (fetch) begin
         data_q <= pix_valid ? pix_data : '0;
         if (!pix_valid) underflow <= 1'b1;
      end else if (blank_tick) begin
         data_q <= '0;
      end
   end
endmodule

// File: rtl/lcd_panel_timer.sv
`timescale 1ns/1ps
module lcd_panel_timer
   import lcdt_pkg::*;
#(
   parameter int WW      = 7,
   parameter int NW      = 5,
   parameter int LW      = 9,
   parameter int DW      = 8,
   parameter int MOD_DLY = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [WW-1:0] cfg_width,
   input  logic [NW-1:0] cfg_blank,
   input  logic [LW-1:0] cfg_lines,
   input  logic          cfg_mask_shift,
   input  logic [DW-1:0] pix_data,
   input  logic          pix_valid,
   output logic          pix_ready,
   output logic          lcd_frame,
   output logic          lcd_line,
   output logic          lcd_shift,
   output logic          lcd_mod,
   output logic [DW-1:0] lcd_data,
   output logic          underflow
);
   localparam int HW = $clog2(max_line_len(WW, NW));

   if (WW < 1 || WW > 10) begin : g_bad_ww
      $error("lcd_panel_timer: WW out of range");
   end
   if (NW < 1 || NW > 8) begin : g_bad_nw
      $error("lcd_panel_timer: NW out of range");
   end
   if (LW < 1 || DW < 1) begin : g_bad_w
      $error("lcd_panel_timer: LW and DW must be positive");
   end
   if (MOD_DLY < 1 || MOD_DLY > LP_FALL_OFS - LP_RISE_OFS - 1) begin : g_bad_mod
      $error("lcd_panel_timer: MOD_DLY must fall inside the line pulse");
   end

   logic          line_end, fetch, blank_tick, shift_c, line_c, frame_win, mod_hit;
   logic          frame_c, mod_i;
   logic [DW-1:0] data_i;

   lcdt_hcount #(.WW(WW), .NW(NW), .HW(HW), .MOD_DLY(MOD_DLY)) u_h (
      .clk        (clk),
      .rst        (rst),
      .cfg_width  (cfg_width),
      .cfg_blank  (cfg_blank),
      .mask       (cfg_mask_shift),
      .line_end   (line_end),
      .fetch      (fetch),
      .blank_tick (blank_tick),
      .shift_c    (shift_c),
      .line_c     (line_c),
      .frame_win  (frame_win),
      .mod_hit    (mod_hit)
   );

   lcdt_vcount #(.LW(LW)) u_v (
      .clk       (clk),
      .rst       (rst),
      .line_end  (line_end),
      .cfg_lines (cfg_lines),
      .frame_win (frame_win),
      .mod_hit   (mod_hit),
      .frame_c   (frame_c),
      .mod_i     (mod_i)
   );

   lcdt_fetch #(.DW(DW)) u_f (
      .clk        (clk),
      .rst        (rst),
      .fetch      (fetch),
      .blank_tick (blank_tick),
      .pix_data   (pix_data),
      .pix_valid  (pix_valid),
      .pix_ready  (pix_ready),
      .data_q     (data_i),
      .underflow  (underflow)
   );

   // all panel signals share one path so their relative timing is fixed
   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (rst) begin
            lcd_frame <= 1'b0;
            lcd_line  <= 1'b0;
            lcd_shift <= 1'b0;
            lcd_mod   <= 1'b0;
            lcd_data  <= '0;
         end else begin
            lcd_frame <= frame_c;
            lcd_line  <= line_c;
            lcd_shift <= shift_c;
            lcd_mod   <= mod_i;
            lcd_data  <= data_i;
         end
      end
   end else begin : g_comb_out
      assign lcd_frame = frame_c && !rst;
      assign lcd_line  = line_c && !rst;
      assign lcd_shift = shift_c && !rst;
      assign lcd_mod   = mod_i;
      assign lcd_data  = data_i;
   end
endmodule

// File: rtl/lcdt_checker.sv
`timescale 1ns/1ps
module lcdt_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          cfg_mask_shift,
   input logic          pix_ready,
   input logic          lcd_frame,
   input logic          lcd_line,
   input logic          lcd_shift,
   input logic          lcd_mod,
   input logic [DW-1:0] lcd_data,
   input logic          underflow
);
   // R1: panel outputs idle during reset (after the first edge)
   p_reset_idle_r1: assert property (@(posedge clk)
      $past(rst) && rst |-> !lcd_line && !lcd_frame && !lcd_shift && !underflow);

   // R3: line pulse lasts nine clocks
   p_line_width_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(lcd_line) |-> $past(lcd_line, 9) && !$past(lcd_line, 10));

   // R4: masked shift clock stays low under the line pulse
   p_shift_masked_r4: assert property (@(posedge clk) disable iff (rst)
      (cfg_mask_shift && $past(cfg_mask_shift) && lcd_line) |-> !lcd_shift);

   // R6: frame pulse held four clocks past the line pulse falling edge
   p_frame_hold_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(lcd_frame) |-> !$past(lcd_line, 4) && $past(lcd_line, 5));

   // R7: the AC toggle only moves while the line pulse is high
   p_mod_in_line_r7: assert property (@(posedge clk) disable iff (rst)
      !$stable(lcd_mod) |-> lcd_line);

   // R8: no byte request and no data during the line pulse
   p_blank_data_r8: assert property (@(posedge clk) disable iff (rst)
      lcd_line |-> (lcd_data == '0) && !pix_ready);

   // R9: underflow flag is sticky
   p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      $past(underflow) |-> underflow);
endmodule

bind lcd_panel_timer lcdt_checker #(.DW(DW)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .cfg_mask_shift (cfg_mask_shift),
   .pix_ready      (pix_ready),
   .lcd_frame      (lcd_frame),
   .lcd_line       (lcd_line),
   .lcd_shift      (lcd_shift),
   .lcd_mod        (lcd_mod),
   .lcd_data       (lcd_data),
   .underflow      (underflow)
);

// File: tb/sim_lcd_panel_timer.sv
`timescale 1ns/1ps
module sim_lcd_panel_timer;
   localparam int WW = 7, NW = 5, LW = 9, DW = 8, MOD_DLY = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [WW-1:0] cfg_width = '0;
   logic [NW-1:0] cfg_blank = '0;
   logic [LW-1:0] cfg_lines = '0;
   logic          cfg_mask_shift = 1'b1;
   logic [DW-1:0] pix_data = '0;
   logic          pix_valid = 1'b0;
   logic          pix_ready, lcd_frame, lcd_line, lcd_shift, lcd_mod, underflow;
   logic [DW-1:0] lcd_data;

   always #2.5 clk = ~clk;

   lcd_panel_timer #(.WW(WW), .NW(NW), .LW(LW), .DW(DW), .MOD_DLY(MOD_DLY), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_blank(cfg_blank),
      .cfg_lines(cfg_lines), .cfg_mask_shift(cfg_mask_shift),
      .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .lcd_frame(lcd_frame), .lcd_line(lcd_line), .lcd_shift(lcd_shift),
      .lcd_mod(lcd_mod), .lcd_data(lcd_data), .underflow(underflow)
   );

   int n_chk = 0, n_bad = 0;
   // monitor state
   int cyc = 0, n_rise = 0, last_rise = 0, prev_rise = 0, last_sfall = 0;
   int gap_sf = 0, sfalls = 0, sf_line = 0, width = 0, last_fall = 0;
   int fr_rise = 0, fr_per = 0, setup = 0, hold = 0;
   int mod_c = 0, mod_dly = 0, mod_per = 0, shift_in_line = 0;
   int ncap = 0, ncons = 0;
   int cap [64];
   int cons [64];
   logic pl = 0, ps = 0, pf = 0, pm = 0;
   // source state
   bit src_en = 1'b1;
   int seq = 1;

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // byte source: updates a moment after the edge that consumed a byte
   initial begin
      forever begin
         bit take;
         @(negedge clk);
         take = pix_ready && pix_valid;
         @(posedge clk);
         #1;
         if (take) seq = (seq % 255) + 1;
         pix_data  = DW'(seq);
         pix_valid = src_en;
      end
   end

   // edge monitor, sampled away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst) begin
            if (lcd_line && !pl) begin
               n_rise++; prev_rise = last_rise; last_rise = cyc;
               gap_sf = cyc - last_sfall; sf_line = sfalls; sfalls = 0;
            end
            if (!lcd_line && pl) begin
               last_fall = cyc; width = cyc - last_rise;
               if (lcd_frame) setup = cyc - fr_rise;
            end
            if (!lcd_shift && ps) begin
               sfalls++; last_sfall = cyc;
               if (ncap < 64) begin cap[ncap] = int'(lcd_data); ncap++; end
            end
            if (lcd_line && lcd_shift) shift_in_line++;
            if (lcd_frame && !pf) begin fr_per = cyc - fr_rise; fr_rise = cyc; end
            if (!lcd_frame && pf) hold = cyc - last_fall;
            if (lcd_mod != pm) begin mod_dly = cyc - last_rise; mod_per = cyc - mod_c; mod_c = cyc; end
            if (pix_ready && ncons < 64) begin
               cons[ncons] = pix_valid ? int'(pix_data) : 0; ncons++;
            end
         end
         pl = lcd_line; ps = lcd_shift; pf = lcd_frame; pm = lcd_mod;
      end
   end

   task automatic wait_rises(input int n);
      int target = n_rise + n;
      while (n_rise < target) @(negedge clk);
   endtask

   task automatic apply(input int w, input int n, input int l, input bit mask);
      @(negedge clk);
      rst = 1'b1;
      cfg_width = WW'(w); cfg_blank = NW'(n); cfg_lines = LW'(l); cfg_mask_shift = mask;
      repeat (3) @(negedge clk);
      n_rise = 0; last_rise = 0; prev_rise = 0; last_sfall = 0; sfalls = 0;
      fr_rise = 0; mod_c = 0; ncap = 0; ncons = 0; shift_in_line = 0;
      rst = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk_eq("R1", "frame in reset", int'(lcd_frame), 0);
      chk_eq("R1", "line in reset", int'(lcd_line), 0);
      chk_eq("R1", "shift in reset", int'(lcd_shift), 0);
      chk_eq("R1", "mod in reset", int'(lcd_mod), 0);
      chk_eq("R1", "data in reset", int'(lcd_data), 0);
      chk_eq("R1", "underflow in reset", int'(underflow), 0);
      chk_eq("R1", "ready in reset", int'(pix_ready), 0);
   endtask

   task automatic t_run(input int w, input int n, input int l, input bit mask);
      int p = (w + 1) * 8 + (n + 4) * 8;
      int bad = 0;
      src_en = 1'b1;
      apply(w, n, l, mask);
      wait_rises((l + 1) * 2 + 2);
      chk_eq("R2", "line period", last_rise - prev_rise, p);
      chk_eq("R3", "line width", width, 9);
      if (mask) begin
         chk_eq("R3", "last shift fall to line rise", gap_sf, 8 * n + 4);
         chk_eq("R4", "shift edges per line", sf_line, w + 1);
         chk_eq("R4", "shift high under line", shift_in_line, 0);
      end else begin
         chk_eq("R5", "shift edges per line", sf_line, p / 8);
         chk_eq("R5", "shift active under line", int'(shift_in_line > 0), 1);
      end
      chk_eq("R6", "frame setup", setup, 13);
      chk_eq("R6", "frame hold", hold, 4);
      chk_eq("R6", "frame period", fr_per, (l + 1) * p);
      chk_eq("R7", "mod delay", mod_dly, MOD_DLY);
      chk_eq("R7", "mod period", mod_per, (l + 1) * p);
      if (mask) begin
         for (int i = 0; i < ncap; i++) if (i < ncons && cap[i] != cons[i]) bad++;
         chk_eq("R8", "captured bytes match", bad, 0);
         chk_eq("R8", "byte count equals edge count", ncap, ncons);
      end
      chk_eq("R9", "no underflow with valid data", int'(underflow), 0);
   endtask

   task automatic t_underflow();
      int bad = 0;
      src_en = 1'b0;
      apply(3, 0, 1, 1'b1);
      wait_rises(2);
      chk_eq("R9", "underflow raised", int'(underflow), 1);
      for (int i = 0; i < ncap; i++) if (cap[i] != 0) bad++;
      chk_eq("R9", "starved bytes are zero", bad, 0);
      chk_eq("R9", "starved edges seen", int'(ncap >= 4), 1);
      src_en = 1'b1;
      wait_rises(2);
      chk_eq("R9", "underflow sticky", int'(underflow), 1);
   endtask

   task automatic t_shadow();
      src_en = 1'b1;
      apply(5, 1, 2, 1'b1);
      wait_rises(3);
      repeat (38) @(negedge clk);
      cfg_width = WW'(2);
      wait_rises(1);
      chk_eq("R10", "old width kept mid-line", sf_line, 6);
      wait_rises(1);
      chk_eq("R10", "new width next line", sf_line, 3);
      chk_eq("R10", "new period next line", last_rise - prev_rise, 3 * 8 + 5 * 8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_run(3, 0, 3, 1'b1);
      t_reset();
      t_run(9, 2, 4, 1'b0);
      t_run(6, 5, 1, 1'b1);
      t_underflow();
      t_shadow();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule